// File: doc/BRIEF.md
# Receive Buffer Writer

The block takes one accepted receive packet, arriving as a stream of 16-bit words, and lays it into a memory buffer. A start pulse supplies the buffer base address and its length in words. While four or more words of room remain, incoming words are gathered into groups of four, and each group goes to memory only once it is complete. The words that fit in the tail of the buffer, past the last full group, go out one at a time as they arrive. Memory is reached through a plain one-word-per-cycle write port, fed from a small internal queue, so input words never wait.

End of packet comes as a pulse carrying the hardware status word. The block then works out how many buffer words the packet really used, dropping the trailing CRC word and a 2-bit excess count taken from the status. It also builds a 16-bit completion word. That word tells a good packet apart from a buffer too short to use, a packet that overran its buffer, and a packet the receive hardware flagged as bad, with the flagged status bits folded in. When every write of the packet has gone out, a one-cycle done pulse follows. Chaining to further buffers and raising interrupts are handled elsewhere.

Top module: `rx_buf_writer`

## Requirements
- R1: A buffer length below 4 words gives completion 0x6800 (octal 064000) and a used count of 0, and no memory write occurs for that packet.
- R2: Packet word i (counting from 0 at each start) is written to address base + i with its data unchanged, in arrival order. Only words with i below the buffer length are written.
- R3: A word whose group of four (words 4k to 4k+3) lies entirely within the buffer is written only after all four words of its group have arrived, or after end of packet. Words beyond the last whole group are written without waiting for later words.
- R4: One word arriving after the buffer is exactly full is taken as the CRC. It is not written, and the packet completes as good or hardware-error as usual.
- R5: If two or more words arrive beyond the buffer length, completion is 0x6200 (octal 061000) and the used count equals the buffer length. Buffer-too-short (R1) has priority over overrun, and overrun has priority over hardware status.
- R6: If neither R1 nor R5 applies, the used count is the number of words received in the packet minus the excess count in status bits 9:8, minus 1 for the CRC. It floors at 0.
- R7: The error mask is 0xA900 (bits 15, 13, 11 and 8). If no status bit under the mask is set and neither R1 nor R5 applies, completion is 0x4000 (octal 040000).
- R8: If masked status bits are set and neither R1 nor R5 applies, completion is 0x7000 ORed with the masked status shifted right by 8.
- R9: done_o is high for exactly one cycle per packet. It comes after completion_o and used_o have taken their new values and after the last memory write of the packet. completion_o and used_o hold their values until the next end of packet.
- R10: After reset there are no memory writes, done_o is low, and completion_o and used_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a packet; latches base and length |
| base_i | input | ADDR_W | Buffer base word address |
| len_i | input | LEN_W | Buffer length in words |
| word_valid_i | input | 1 | word_i holds a packet word this cycle |
| word_i | input | 16 | Packet data word |
| eop_i | input | 1 | End of packet; status_i valid |
| status_i | input | 16 | Receive hardware status word |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | 16 | Memory write data |
| done_o | output | 1 | One-cycle packet-finished pulse |
| completion_o | output | 16 | Completion word of the last packet |
| used_o | output | LEN_W | Used word count of the last packet |

## Verification
The checks assume a well-formed caller. start_i is raised only while the block is idle, that is before the first packet or after done_o. word_valid_i and eop_i are never high in the same cycle. At most one word arrives per cycle, and no word or end-of-packet arrives outside a started packet. The stimulus tasks keep to this: each packet is started, fed back-to-back or with gaps, ended once, and the next one starts only after the done pulse. Under these limits the write queue never holds more than seven entries, and its assertion depends on that bound.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam logic [15:0] CMPL_GOOD  = 16'h4000;
  localparam logic [15:0] CMPL_SHORT = 16'h6800;
  localparam logic [15:0] CMPL_OVR   = 16'h6200;
  localparam logic [15:0] CMPL_HWERR = 16'h7000;
  localparam logic [15:0] ERR_MASK   = 16'hA900;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } wr_state_e;
endpackage

// File: rtl/rxw_cmpl_enc.sv
module rxw_cmpl_enc
  import rxw_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             short_i,
  input  logic             ovr_i,
  input  logic [15:0]      status_i,
  input  logic [LEN_W:0]   rx_cnt_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [15:0]      cmpl_o,
  output logic [LEN_W-1:0] used_o
);
  logic [15:0]    masked;
  logic [LEN_W:0] excess_w;
  logic [LEN_W:0] net;

  assign masked   = status_i & ERR_MASK;
  assign excess_w = (LEN_W+1)'(status_i[9:8]);

  always_comb begin
    net = '0;
    if (rx_cnt_i > excess_w) net = rx_cnt_i - excess_w - 1'b1;
  end

  always_comb begin
    if (short_i)              cmpl_o = CMPL_SHORT;
    else if (ovr_i)           cmpl_o = CMPL_OVR;
    else if (masked != '0)    cmpl_o = CMPL_HWERR | (masked >> 8);
    else                      cmpl_o = CMPL_GOOD;
  end

  always_comb begin
    if (short_i)          used_o = '0;
    else if (ovr_i)       used_o = len_i;
    else if (net[LEN_W])  used_o = '1;  // clamp; unreachable for legal counts
    else                  used_o = net[LEN_W-1:0];
  end
endmodule

// File: rtl/rxw_wq.sv
module rxw_wq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [2:0]        commit_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  occ, cmt;
  logic              pop;

  // entries leave only once released by a commit
  assign pop    = (cmt != '0);
  assign we_o   = pop;
  assign addr_o = addr_mem[rd_ptr];
  assign data_o = data_mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_mem[wr_ptr] <= push_addr_i;
      data_mem[wr_ptr] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      cmt    <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    rd_ptr <= rd_ptr + 1'b1;
      occ <= occ + CNT_W'(push_i) - CNT_W'(pop);
      cmt <= cmt + CNT_W'(commit_i) - CNT_W'(pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (occ < CNT_W'(DEPTH)) || pop);

  p_commit_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W+1)'(cmt) + (CNT_W+1)'(commit_i) <= (CNT_W+1)'(occ) + (CNT_W+1)'(push_i));
endmodule

// File: rtl/rx_buf_writer.sv
module rx_buf_writer
  import rxw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int QDEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              word_valid_i,
  input  logic [15:0]       word_i,
  input  logic              eop_i,
  input  logic [15:0]       status_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              done_o,
  output logic [15:0]       completion_o,
  output logic [LEN_W-1:0]  used_o
);
  localparam int GRP = 4;

  wr_state_e         state_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W:0]    rx_cnt_q;
  logic [1:0]        grp_q;
  logic              short_q, ovr_q;

  logic              in_run, acc, store, in_quad;
  logic [LEN_W:0]    len_w, quad_lim;
  logic [2:0]        commit;
  logic [15:0]       cmpl_d;
  logic [LEN_W-1:0]  used_d;

  assign in_run   = (state_q == ST_RUN);
  assign len_w    = {1'b0, len_q};
  assign quad_lim = {1'b0, len_q[LEN_W-1:2], 2'b00};
  assign acc      = in_run && word_valid_i && !short_q && !ovr_q;
  assign store    = acc && (rx_cnt_q < len_w);
  assign in_quad  = (rx_cnt_q < quad_lim);

  always_comb begin
    commit = 3'd0;
    if (in_run && eop_i)                  commit = {1'b0, grp_q};
    else if (store && !in_quad)           commit = 3'd1;
    else if (store && grp_q == 2'(GRP-1)) commit = 3'(GRP);
  end

  rxw_wq #(
    .ADDR_W(ADDR_W),
    .DATA_W(16),
    .DEPTH (QDEPTH)
  ) u_wq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (store),
    .push_addr_i(base_q + ADDR_W'(rx_cnt_q[LEN_W-1:0])),
    .push_data_i(word_i),
    .commit_i   (commit),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .data_o     (mem_wdata_o)
  );

  rxw_cmpl_enc #(.LEN_W(LEN_W)) u_enc (
    .short_i (short_q),
    .ovr_i   (ovr_q),
    .status_i(status_i),
    .rx_cnt_i(rx_cnt_q),
    .len_i   (len_q),
    .cmpl_o  (cmpl_d),
    .used_o  (used_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      base_q       <= '0;
      len_q        <= '0;
      rx_cnt_q     <= '0;
      grp_q        <= '0;
      short_q      <= 1'b0;
      ovr_q        <= 1'b0;
      done_o       <= 1'b0;
      completion_o <= '0;
      used_o       <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q   <= base_i;
            len_q    <= len_i;
            rx_cnt_q <= '0;
            grp_q    <= '0;
            short_q  <= (len_i < LEN_W'(GRP));
            ovr_q    <= 1'b0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (eop_i) begin
            completion_o <= cmpl_d;
            used_o       <= used_d;
            grp_q        <= '0;
            state_q      <= ST_FLUSH;
          end else if (acc) begin
            // index len is the CRC slot; one past it is an overrun
            if (rx_cnt_q > len_w) ovr_q <= 1'b1;
            else                  rx_cnt_q <= rx_cnt_q + 1'b1;
            if (store && in_quad) grp_q <= grp_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (!mem_we_o) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_short_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && short_q) |-> !mem_we_o);

  p_addr_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_addr_o - base_q) < ADDR_W'(len_q)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_drained_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o);

  p_result_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_run && eop_i) |=> $stable(completion_o) && $stable(used_o));

  p_in_word_eop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && eop_i));

  p_in_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE));
endmodule

// File: tb/rx_buf_writer_test.sv
module rx_buf_writer_test;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic [LEN_W-1:0]  len = '0;
  logic              word_valid = 1'b0;
  logic [15:0]       word = '0;
  logic              eop = 1'b0;
  logic [15:0]       status = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0]       mem_wdata;
  logic              done;
  logic [15:0]       completion;
  logic [LEN_W-1:0]  used;

  rx_buf_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .QDEPTH(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .len_i(len),
    .word_valid_i(word_valid), .word_i(word), .eop_i(eop), .status_i(status),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .done_o(done), .completion_o(completion), .used_o(used)
  );

  always #5 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  logic [31:0] exp_wr[$];
  int          exp_ix[$];
  int          words_sent = 0;
  bit          eop_sent = 0;
  int          quad_lim_cur = 0;
  bit          exp_done = 0;
  bit          done_seen = 0;
  logic [15:0] exp_cmpl = '0;
  int          exp_used = 0;
  logic [15:0] prev_cmpl = '0;
  string       cur_tag = "";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int b, input int i);
    return 16'(b * 7 + i * 291) ^ 16'hA5A5;
  endfunction

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_wr.size() == 0) begin
          chk("R2 unexpected write", {mem_addr, mem_wdata}, 32'hFFFF_FFFF);
        end else begin
          int ix;
          logic [31:0] e;
          e  = exp_wr.pop_front();
          ix = exp_ix.pop_front();
          chk("R2 write addr/data", {mem_addr, mem_wdata}, e);
          if (ix < quad_lim_cur && !eop_sent)
            chk("R3 group complete before write", 32'(words_sent >= (ix / 4) * 4 + 4), 32'd1);
        end
      end
      if (done) begin
        if (!exp_done) begin
          chk("R9 unexpected done", 32'd1, 32'd0);
        end else begin
          chk({cur_tag, " completion"}, 32'(completion), 32'(exp_cmpl));
          chk({cur_tag, " used"}, 32'(used), 32'(exp_used));
          chk("R9 writes drained at done", 32'(exp_wr.size()), 32'd0);
          exp_done  = 0;
          done_seen = 1;
        end
      end else if (done_seen) begin
        chk("R9 done single cycle", 32'(done), 32'd0);
        done_seen = 0;
      end
    end
  end

  task automatic run_pkt(input int b, input int l, input int n, input logic [15:0] st,
                         input int gap_mode, input string tag);
    logic [15:0] masked;
    int          r;
    cur_tag = tag;
    exp_wr.delete();
    exp_ix.delete();
    quad_lim_cur = (l / 4) * 4;
    for (int i = 0; i < n; i++)
      if (l >= 4 && i < l) begin
        exp_wr.push_back({16'(b + i), pat(b, i)});
        exp_ix.push_back(i);
      end
    masked = st & 16'hA900;
    if (l < 4) begin
      exp_cmpl = 16'h6800; exp_used = 0;
    end else if (n > l + 1) begin
      exp_cmpl = 16'h6200; exp_used = l;
    end else begin
      exp_cmpl = (masked != 0) ? (16'h7000 | (masked >> 8)) : 16'h4000;
      r = n - int'(st[9:8]) - 1;
      exp_used = (r < 0) ? 0 : r;
    end
    words_sent = 0;
    eop_sent   = 0;
    @(posedge clk); #1;
    start = 1'b1; base = 16'(b); len = LEN_W'(l);
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      word_valid = 1'b1;
      word = pat(b, i);
      words_sent++;
      @(posedge clk); #1;
      word_valid = 1'b0;
      if (gap_mode == 1 || (gap_mode == 2 && i % 3 == 0)) begin
        @(posedge clk); #1;
      end
    end
    chk("R9 previous completion held", 32'(completion), 32'(prev_cmpl));
    eop = 1'b1; status = st; eop_sent = 1; exp_done = 1;
    @(posedge clk); #1;
    eop = 1'b0;
    for (int k = 0; k < 60 && exp_done; k++) @(posedge clk);
    if (exp_done) chk({tag, " done missing"}, 32'd0, 32'd1);
    exp_done  = 0;
    prev_cmpl = exp_cmpl;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset we", 32'(mem_we), 32'd0);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R10 reset completion", 32'(completion), 32'd0);
    chk("R10 reset used", 32'(used), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    run_pkt(16'h0100, 16, 12, 16'h0000, 0, "R7 good back-to-back");
    run_pkt(16'h0200, 10, 7,  16'h0200, 2, "R6 partial group excess 2");
    run_pkt(16'h0300, 10, 11, 16'h0000, 1, "R4 full plus CRC");
    run_pkt(16'h0400, 10, 12, 16'h8000, 0, "R5 overrun priority");
    run_pkt(16'h0500, 10, 15, 16'h0000, 2, "R5 long overrun");
    run_pkt(16'h0600, 3,  5,  16'hA900, 0, "R1 short buffer");
    run_pkt(16'h0700, 0,  2,  16'h0000, 1, "R1 zero length");
    run_pkt(16'h0800, 20, 14, 16'hAB00, 0, "R8 all errors excess 3");
    run_pkt(16'h0900, 20, 9,  16'h5600 | 16'h0100, 2, "R8 single error bit");
    run_pkt(16'h0A00, 20, 9,  16'h5600, 0, "R7 unmasked bits only");
    run_pkt(16'h0B00, 8,  0,  16'h0000, 0, "R6 empty packet floor");
    run_pkt(16'h0C00, 4,  5,  16'h0100, 0, "R4 single group plus CRC");
    run_pkt(16'h0D00, 9,  10, 16'h0000, 0, "R3 tail single word");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule